// File: doc/BRIEF.md
# Multi-Format Signed Adder/Subtractor

This unit adds or subtracts two signed operands of a parameterised width `WIDTH`. The operands and the result all use one of three encodings, picked per operation: sign-magnitude, one's complement or two's complement. A single datapath serves all three. Each encoding has its own carry rule: no carry between the sign and magnitude fields, a wrapped carry that folds back into the LSB, or a carry that is dropped. Each also has its own rule for how overflow is detected.

An operation is presented with `in_valid` high. One clock later, the result and four flags appear on registered outputs together with a one-cycle `out_valid` pulse. When `in_valid` is low, the outputs keep their last values. The zero flag treats both encodings of zero as zero in the formats that have two of them.

Top module: `msc_addsub`

## Requirements
- R1: `fmt` selects the encoding: 2'b00 is sign-magnitude (MSB is the sign, 1 means negative, the low WIDTH-1 bits are the magnitude), 2'b01 is one's complement, 2'b10 and 2'b11 are both two's complement. `sub`=1 computes A-B and `sub`=0 computes A+B.
- R2: Sign-magnitude, effective signs equal (the effective sign of B is its sign bit XOR `sub`): the magnitudes are summed and the result carries the common sign.
- R3: Sign-magnitude, effective signs differ: the smaller magnitude is taken from the larger and the result takes the sign of the larger. When the magnitudes are equal, the result is a zero magnitude with the sign of A. Overflow is never flagged in this case.
- R4: One's complement: subtraction adds the bitwise complement of B. A carry out of the MSB is added back into the LSB, and the carry flag reports that carry. A zero result is all ones unless A and the complemented B are both all zeros.
- R5: Two's complement: subtraction adds the complement of B plus one. The result is the sum modulo 2^WIDTH, and the carry flag is the carry out of the MSB.
- R6: Two's complement overflow is flagged when the carry into the MSB differs from the carry out of the MSB. For WIDTH=4, 5+3 gives 4'b1000 with overflow and -7-2 gives 4'b0111 with overflow.
- R7: In sign-magnitude and one's complement, overflow is flagged exactly when the magnitude of the true result exceeds 2^(WIDTH-1)-1. On a sign-magnitude overflow, the result holds the low WIDTH-1 bits of the magnitude sum with the common sign, and the carry flag equals the overflow flag. A sign-magnitude operation with differing effective signs gives carry 0.
- R8: The zero flag is set when the result pattern encodes zero, which includes both +0 and -0 where two exist. The negative flag is set only when the result encodes a nonzero negative value, so it is never set for -0.
- R9: Result and flags are registered on the clock edge at which `in_valid` is high, and `out_valid` is high for the following cycle. With `in_valid` low, `out_valid` falls and result and flags hold.
- R10: Asynchronous active-low reset clears the result, all four flags and `out_valid` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation strobe |
| fmt | input | 2 | Encoding select |
| sub | input | 1 | 1 = subtract B from A |
| op_a | input | WIDTH | Operand A |
| op_b | input | WIDTH | Operand B |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| result | output | WIDTH | Result in the selected encoding |
| flag_ovf | output | 1 | Overflow |
| flag_carry | output | 1 | Carry out (end-around carry in one's complement) |
| flag_neg | output | 1 | Nonzero negative result |
| flag_zero | output | 1 | Result encodes zero |

## Verification
On every cycle, the assertions check the valid pipeline and the hold behaviour. They also check that zero and negative are never flagged together. Three encoding-specific rules are checked as well: sign-magnitude operations with differing signs never overflow, a two's-complement overflow always pairs equal operand signs with a flipped result sign, and a one's-complement +0 result comes only from two all-zero addends. The exact result patterns cannot be shown by those properties. These include the sign given to a zero in sign-magnitude, the wrapped pattern on overflow, and the carry flag in each encoding. They come from the bench's exhaustive sweep at WIDTH=4, which compares each output against a value-level integer model across every operand pair, both operations and all four format codes.

// File: rtl/msc_pkg.sv
`timescale 1ns/1ps
package msc_pkg;
  typedef enum logic [1:0] {
    FMT_SIGNMAG  = 2'b00,
    FMT_ONESC    = 2'b01,
    FMT_TWOSC    = 2'b10,
    FMT_TWOSC_B  = 2'b11
  } fmt_e;

  typedef struct packed {
    logic ovf;
    logic carry;
    logic neg;
    logic zero;
  } flags_t;
endpackage

// File: rtl/msc_signmag_path.sv
`timescale 1ns/1ps
module msc_signmag_path #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] res,
  output logic         ovf,
  output logic         carry,
  output logic         signs_differ
);
  localparam int MW = W - 1;

  logic          sa;
  logic          sb_eff;
  logic [MW-1:0] ma;
  logic [MW-1:0] mb;
  logic [MW:0]   mag_sum;
  logic [MW-1:0] mag_diff;
  logic          a_ge_b;

  function automatic logic [MW-1:0] abs_diff(input logic [MW-1:0] x,
                                             input logic [MW-1:0] y);
    return (x >= y) ? (x - y) : (y - x);
  endfunction

  always_comb begin
    sa           = a[W-1];
    sb_eff       = b[W-1] ^ sub;
    ma           = a[MW-1:0];
    mb           = b[MW-1:0];
    mag_sum      = {1'b0, ma} + {1'b0, mb};
    a_ge_b       = (ma >= mb);
    mag_diff     = abs_diff(ma, mb);
    signs_differ = (sa != sb_eff);
    if (!signs_differ) begin
      res   = {sa, mag_sum[MW-1:0]};
      ovf   = mag_sum[MW];
      carry = mag_sum[MW];
    end else begin
      res   = {(a_ge_b ? sa : sb_eff), mag_diff};
      ovf   = 1'b0;
      carry = 1'b0;
    end
  end
endmodule

// File: rtl/msc_cplx_path.sv
`timescale 1ns/1ps
module msc_cplx_path #(
  parameter int W          = 8,
  parameter bit END_AROUND = 1'b0
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] res,
  output logic         carry,
  output logic         ovf
);
  logic [W-1:0] b_eff;
  logic         cin;
  logic [W:0]   raw;

  assign b_eff = sub ? ~b : b;
  assign cin   = END_AROUND ? 1'b0 : sub;
  assign raw   = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
  assign carry = raw[W];

  generate
    if (END_AROUND) begin : g_wrap
      logic [W-1:0] folded;
      assign folded = raw[W-1:0] + {{(W-1){1'b0}}, raw[W]};
      assign res    = folded;
      assign ovf    = (a[W-1] == b_eff[W-1]) && (folded[W-1] != a[W-1]);
    end else begin : g_drop
      logic c_into_msb;
      assign c_into_msb = raw[W-1] ^ a[W-1] ^ b_eff[W-1];
      assign res        = raw[W-1:0];
      assign ovf        = c_into_msb ^ raw[W];
    end
  endgenerate
endmodule

// File: rtl/msc_flag_gen.sv
`timescale 1ns/1ps
module msc_flag_gen
  import msc_pkg::*;
#(
  parameter int W = 8
) (
  input  fmt_e         fmt,
  input  logic [W-1:0] res,
  output logic         neg,
  output logic         zero
);
  always_comb begin
    case (fmt)
      FMT_SIGNMAG: begin
        zero = (res[W-2:0] == '0);
        neg  = res[W-1] & ~zero;
      end
      FMT_ONESC: begin
        zero = (res == '0) || (res == '1);
        neg  = res[W-1] & ~zero;
      end
      default: begin
        zero = (res == '0);
        neg  = res[W-1];
      end
    endcase
  end
endmodule

// File: rtl/msc_addsub.sv
`timescale 1ns/1ps
module msc_addsub
  import msc_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       fmt,
  input  logic             sub,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  output logic             out_valid,
  output logic [WIDTH-1:0] result,
  output logic             flag_ovf,
  output logic             flag_carry,
  output logic             flag_neg,
  output logic             flag_zero
);
  localparam int MSB = WIDTH - 1;

  fmt_e             fmt_sel;
  logic [WIDTH-1:0] sm_res, oc_res, tc_res, mux_res;
  logic             sm_ovf, sm_carry, sm_signs_differ;
  logic             oc_ovf, oc_carry;
  logic             tc_ovf, tc_carry;
  flags_t           nxt_flags;

  assign fmt_sel = fmt_e'(fmt);

  msc_signmag_path #(.W(WIDTH)) u_sm (
    .a(op_a), .b(op_b), .sub(sub),
    .res(sm_res), .ovf(sm_ovf), .carry(sm_carry),
    .signs_differ(sm_signs_differ)
  );

  msc_cplx_path #(.W(WIDTH), .END_AROUND(1'b1)) u_oc (
    .a(op_a), .b(op_b), .sub(sub),
    .res(oc_res), .carry(oc_carry), .ovf(oc_ovf)
  );

  msc_cplx_path #(.W(WIDTH), .END_AROUND(1'b0)) u_tc (
    .a(op_a), .b(op_b), .sub(sub),
    .res(tc_res), .carry(tc_carry), .ovf(tc_ovf)
  );

  always_comb begin
    case (fmt_sel)
      FMT_SIGNMAG: begin
        mux_res         = sm_res;
        nxt_flags.ovf   = sm_ovf;
        nxt_flags.carry = sm_carry;
      end
      FMT_ONESC: begin
        mux_res         = oc_res;
        nxt_flags.ovf   = oc_ovf;
        nxt_flags.carry = oc_carry;
      end
      default: begin
        mux_res         = tc_res;
        nxt_flags.ovf   = tc_ovf;
        nxt_flags.carry = tc_carry;
      end
    endcase
  end

  msc_flag_gen #(.W(WIDTH)) u_flags (
    .fmt(fmt_sel), .res(mux_res),
    .neg(nxt_flags.neg), .zero(nxt_flags.zero)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      result     <= '0;
      flag_ovf   <= 1'b0;
      flag_carry <= 1'b0;
      flag_neg   <= 1'b0;
      flag_zero  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result     <= mux_res;
        flag_ovf   <= nxt_flags.ovf;
        flag_carry <= nxt_flags.carry;
        flag_neg   <= nxt_flags.neg;
        flag_zero  <= nxt_flags.zero;
      end
    end
  end

  // R9: strobe follows the request by one cycle
  assert_valid_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R9: idle cycles leave outputs unchanged
  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(result) && $stable(flag_zero)));

  // R8: a zero result is never reported as negative
  assert_zero_not_neg_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(flag_zero && flag_neg));

  // R3: unlike effective signs cannot overflow in sign-magnitude
  assert_sm_unlike_no_ovf_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && fmt_sel == FMT_SIGNMAG && sm_signs_differ) |=> !flag_ovf);

  // R6: two's-complement overflow pairs equal addend signs with a flipped result sign
  assert_tc_ovf_signs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tc_ovf |-> ((op_a[MSB] == (op_b[MSB] ^ sub)) && (tc_res[MSB] != op_a[MSB])));

  // R4: a one's-complement +0 only arises from two all-zero addends
  assert_oc_pos_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_res == '0) |-> ((op_a == '0) && (op_b == (sub ? '1 : '0))));
endmodule

// File: tb/msc_addsub_bench.sv
`timescale 1ns/1ps
module msc_addsub_bench;
  localparam int W    = 4;
  localparam int MOD  = 1 << W;
  localparam int LIM  = (1 << (W - 1)) - 1;
  localparam int MASK = MOD - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [1:0]   fmt = 2'b00;
  logic         sub = 1'b0;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic         out_valid;
  logic [W-1:0] result;
  logic         flag_ovf, flag_carry, flag_neg, flag_zero;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  msc_addsub #(.WIDTH(W)) u_msc_addsub (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fmt(fmt), .sub(sub),
    .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .result(result),
    .flag_ovf(flag_ovf), .flag_carry(flag_carry),
    .flag_neg(flag_neg), .flag_zero(flag_zero)
  );

  function automatic int decode(input int f, input int pat);
    int mag;
    if (f == 0) begin
      mag = pat & LIM;
      return ((pat >> (W - 1)) & 1) ? -mag : mag;
    end else if (f == 1) begin
      return ((pat >> (W - 1)) & 1) ? -((~pat) & MASK) : pat;
    end
    return ((pat >> (W - 1)) & 1) ? pat - MOD : pat;
  endfunction

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  // value-level reference: {res, ovf, carry, neg, zero}
  function automatic logic [W+3:0] model(input int f, input int s, input int a, input int b);
    int va, vb, t, r, eb, sum;
    logic ov, cy;
    va = decode(f, a);
    vb = decode(f, b);
    t  = s ? va - vb : va + vb;
    if (f == 0) begin
      ov = iabs(t) > LIM;
      cy = ov;
      if (t == 0) r = a & (1 << (W - 1));
      else        r = ((t < 0) ? (1 << (W - 1)) : 0) | (iabs(t) % (1 << (W - 1)));
    end else if (f == 1) begin
      eb  = s ? ((~b) & MASK) : b;
      sum = a + eb;
      cy  = sum >= MOD;
      if (cy) sum = sum - MOD + 1;
      r   = sum;
      ov  = (t > LIM) || (t < -LIM);
    end else begin
      eb  = s ? (((~b) & MASK) + 1) : b;
      sum = a + eb;
      cy  = sum >= MOD;
      r   = sum % MOD;
      ov  = (t > LIM) || (t < -(LIM + 1));
    end
    return {r[W-1:0], ov, cy, decode(f, r) < 0, decode(f, r) == 0};
  endfunction

  task automatic check(input string req, input logic [W+4:0] got, input logic [W+4:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got {valid,res,ovf,cy,neg,zero}=%b expected %b", req, got, exp);
    end
  endtask

  task automatic run_vec(input int f, input int s, input int a, input int b, input string req);
    logic [W+3:0] e;
    fmt = f[1:0]; sub = s[0]; op_a = a[W-1:0]; op_b = b[W-1:0]; in_valid = 1'b1;
    e = model(f, s, a, b);
    @(negedge clk);
    check(req, {out_valid, result, flag_ovf, flag_carry, flag_neg, flag_zero}, {1'b1, e});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [W+4:0] held;
    repeat (2) @(negedge clk);
    // R10: reset state
    check("R10", {out_valid, result, flag_ovf, flag_carry, flag_neg, flag_zero}, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed corners
    run_vec(2, 0, 5, 3, "R6 5+3 overflow");
    run_vec(2, 1, 4'b1001, 2, "R6 -7-2 overflow");
    run_vec(2, 1, 3, 0, "R5 subtract zero sets carry");
    run_vec(0, 0, 4'b0011, 4'b1011, "R3 +3 + -3 keeps sign of A");
    run_vec(0, 0, 4'b1011, 4'b0011, "R3 R8 -3 + +3 gives -0");
    run_vec(0, 1, 4'b0010, 4'b0101, "R3 2-5 sign of larger");
    run_vec(0, 0, 4'b0101, 4'b0011, "R2 R7 sign-magnitude overflow wrap");
    run_vec(0, 0, 4'b1010, 4'b1001, "R2 common negative sign");
    run_vec(1, 0, 4'b0011, 4'b1100, "R4 R8 3 + -3 gives all ones");
    run_vec(1, 1, 4'b0100, 4'b0011, "R4 end-around carry");
    run_vec(1, 0, 4'b1000, 4'b1110, "R4 R7 -7 + -1 overflow");
    run_vec(3, 1, 4'b0000, 4'b1000, "R1 code 11 as two's complement");

    // exhaustive sweep, every format code, both operations
    for (int f = 0; f < 4; f++) begin
      for (int s = 0; s < 2; s++) begin
        for (int a = 0; a < MOD; a++) begin
          for (int b = 0; b < MOD; b++) begin
            case (f)
              0:       run_vec(f, s, a, b, "R2 R3 R7 R8 sign-magnitude");
              1:       run_vec(f, s, a, b, "R4 R7 R8 one's complement");
              2:       run_vec(f, s, a, b, "R5 R6 R8 two's complement");
              default: run_vec(f, s, a, b, "R1 R5 R6 code 11");
            endcase
          end
        end
      end
    end

    // R9: idle cycle drops the strobe and holds outputs
    held = {1'b0, result, flag_ovf, flag_carry, flag_neg, flag_zero};
    in_valid = 1'b0; op_a = 4'b0111; op_b = 4'b0001; fmt = 2'b10; sub = 1'b0;
    @(negedge clk);
    check("R9 idle hold", {out_valid, result, flag_ovf, flag_carry, flag_neg, flag_zero}, held);
    @(negedge clk);
    check("R9 idle hold second cycle", {out_valid, result, flag_ovf, flag_carry, flag_neg, flag_zero}, held);
    run_vec(2, 0, 7, 1, "R9 R6 resume after idle");

    // R10: asynchronous reset mid-run
    #2 rst_n = 1'b0;
    #1 check("R10 async clear", {out_valid, result, flag_ovf, flag_carry, flag_neg, flag_zero}, '0);
    finish_run();
  end
endmodule